// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block keeps the wiper state of four digital potentiometers. Each pot owns a 6-bit wiper register, which is volatile, and four 6-bit data registers, which are modelled as nonvolatile. The wiper register can be reloaded in several ways. A host can write it directly or step it up and down by one tap. It can also be copied from one of its pot's data registers, either for a single pot or for all four pots at once. At reset each wiper takes the value of its pot's data register 0. Each wiper value is decoded into a one-hot enable across 64 taps, and these enables drive the resistor switch array outside this block.

Commands arrive already decoded, as a one-cycle `cmd_valid` strobe with an opcode and operand fields. The serial framing is handled upstream, so this block has no valid/ready handshake and never applies back-pressure. A command is either acted on in the cycle it is presented or dropped. A write that targets data registers is only staged when it arrives. The timed commit begins when the upstream logic reports the end of the frame on `frame_end`, which corresponds to chip select rising. While the commit runs, `wip` is high. The commit length is a parameter in clock cycles; at 100 MHz, 10 ms is 1,000,000 cycles.

Top module: `quad_wiper_bank`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `wip` is low. After reset each pot's wiper equals that pot's data register 0. Data register contents are kept through reset.
- R2: Opcode 1 (write wiper) loads `cmd_data` into the wiper of pot `cmd_pot`, and the new value is visible after the next clock edge. A wiper changes only when a command addresses it or when reset is applied.
- R3: Opcode 7 (step) moves the wiper of `cmd_pot` up by one when `cmd_up` is 1 and down by one when it is 0. It stops at 0x3F going up and at 0x00 going down, and never wraps.
- R4: Opcode 2 copies data register `cmd_reg` of pot `cmd_pot` into that pot's wiper on the next clock edge. No busy period follows, and the copy is accepted even while `wip` is high.
- R5: Opcode 3 copies data register `cmd_reg` of every pot into that pot's own wiper, all on the same clock edge.
- R6: For pot p with wiper value w, bit p*64+w of `tap_sel` is the only set bit in field p. Bit 0 of a field is the low end of the array and bit 63 is the high end. `wiper_val` holds pot p's wiper in bits [6p+5:6p].
- R7: Opcode 4 (write data register) stages `cmd_data` for register `cmd_reg` of pot `cmd_pot`. The register does not change until a `frame_end` pulse starts the commit. The new value appears on the edge where `wip` falls.
- R8: A `frame_end` pulse with a write staged and `wip` low raises `wip` on the next edge. `wip` then stays high for exactly NV_CYCLES cycles. Without a staged write, `frame_end` has no effect.
- R9: Opcode 5 stages the current wiper of `cmd_pot` for register `cmd_reg` of that pot. Opcode 6 stages all four wipers for register `cmd_reg` of their own pots. In both cases the value is captured when the command is accepted and is committed as in R7.
- R10: While `wip` is high, opcodes 4, 5 and 6 and `frame_end` are ignored. No later commit writes their data.
- R11: `rd_data` shows data register `rd_reg` of pot `rd_pot` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Opcode: 0 none, 1 write wiper, 2 reg to wiper, 3 global reg to wiper, 4 write reg, 5 wiper to reg, 6 global wiper to reg, 7 step |
| cmd_pot | input | 2 | Pot index |
| cmd_reg | input | 2 | Data register index |
| cmd_data | input | 6 | Write value |
| cmd_up | input | 1 | Step direction, 1 toward the high end |
| frame_end | input | 1 | Pulse at the end of a command frame (chip select rising) |
| rd_pot | input | 2 | Read pot index |
| rd_reg | input | 2 | Read register index |
| rd_data | output | 6 | Selected data register |
| wip | output | 1 | Nonvolatile commit in progress |
| wiper_val | output | 24 | Four packed wiper values |
| tap_sel | output | 256 | Four one-hot 64-tap enable fields |

## Verification
The assertions check rules that hold on every cycle. Each tap field must be one-hot and point at its wiper. Data registers may change only on the edge where a commit ends. `wip` may rise only after `frame_end` and must stay high for exactly the commit length. Nothing may be staged while a commit runs, and a wiper at either end must not move further when stepped past it. What the bench scenarios show instead is the values themselves. These include R0 being reloaded into the wipers after a second reset and the wiper value being captured at command time rather than at commit time. They also include global transfers landing on all pots together, and staged writes waiting for the frame end.

// File: rtl/wbank_pkg.sv
package wbank_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WSET  = 3'd1,
    OP_D2W   = 3'd2,
    OP_GD2W  = 3'd3,
    OP_DSET  = 3'd4,
    OP_W2D   = 3'd5,
    OP_GW2D  = 3'd6,
    OP_STEP  = 3'd7
  } op_e;
endpackage

// File: rtl/wbank_wiper.sv
module wbank_wiper
  import wbank_pkg::*;
#(
  parameter int W   = 6,
  parameter int NR  = 4,
  parameter int PW  = 2,
  parameter int RW  = 2,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  op_e           cmd_op,
  input  logic [PW-1:0] cmd_pot,
  input  logic [RW-1:0] cmd_reg,
  input  logic [W-1:0]  cmd_data,
  input  logic          cmd_up,
  input  logic [NR*W-1:0] row_flat,
  output logic [W-1:0]  wiper
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic         mine;
  logic [W-1:0] pick;
  logic [W-1:0] w_q;

  assign mine  = (cmd_pot == PW'(IDX));
  assign pick  = row_flat[cmd_reg*W +: W];
  assign wiper = w_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q <= row_flat[W-1:0];
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_WSET: if (mine) w_q <= cmd_data;
        OP_D2W:  if (mine) w_q <= pick;
        OP_GD2W: w_q <= pick;
        OP_STEP: begin
          if (mine) begin
            if (cmd_up) begin
              if (w_q != TOP) w_q <= w_q + 1'b1;
            end else begin
              if (w_q != '0) w_q <= w_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  step_top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_STEP && mine && cmd_up && w_q == TOP) |=> (w_q == TOP));

  // R3
  step_bottom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_STEP && mine && !cmd_up && w_q == '0) |=> (w_q == '0));

  // R2
  wiper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid) |=> $stable(w_q));
endmodule

// File: rtl/wbank_tapdec.sv
module wbank_tapdec #(
  parameter int W    = 6,
  parameter int TAPS = 64
) (
  input  logic [W-1:0]    wiper,
  output logic [TAPS-1:0] tap
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap[t] = (wiper == W'(t));
  end
endmodule

// File: rtl/wbank_nvstore.sv
module wbank_nvstore
  import wbank_pkg::*;
#(
  parameter int W         = 6,
  parameter int NP        = 4,
  parameter int NR        = 4,
  parameter int NV_CYCLES = 1000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  op_e                    cmd_op,
  input  logic [$clog2(NP)-1:0]  cmd_pot,
  input  logic [$clog2(NR)-1:0]  cmd_reg,
  input  logic [W-1:0]           cmd_data,
  input  logic [NP*W-1:0]        wiper_flat,
  input  logic                   frame_end,
  output logic [NP*NR*W-1:0]     store_flat,
  output logic                   busy
);
  localparam int PW = $clog2(NP);
  localparam int RW = $clog2(NR);
  localparam int CW = $clog2(NV_CYCLES + 1);

  logic              pend_q;
  logic [NP-1:0]     mask_q;
  logic [RW-1:0]     reg_q;
  logic [NP*W-1:0]   stage_q;
  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  logic [NP*NR*W-1:0] store_q;
  logic              nv_op;
  logic              start;
  logic              accept;
  logic              finish;

  assign nv_op  = (cmd_op == OP_DSET) || (cmd_op == OP_W2D) || (cmd_op == OP_GW2D);
  assign start  = frame_end && pend_q && !busy_q;
  assign accept = cmd_valid && nv_op && !busy_q && !start;
  assign finish = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      mask_q  <= '0;
      reg_q   <= '0;
      stage_q <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (busy_q) begin
        if (finish) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q - 1'b1;
      end else if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(NV_CYCLES - 1);
        pend_q <= 1'b0;
      end else if (accept) begin
        pend_q <= 1'b1;
        reg_q  <= cmd_reg;
        case (cmd_op)
          OP_DSET: begin
            mask_q <= NP'(1) << cmd_pot;
            stage_q[cmd_pot*W +: W] <= cmd_data;
          end
          OP_W2D: begin
            mask_q <= NP'(1) << cmd_pot;
            stage_q[cmd_pot*W +: W] <= wiper_flat[cmd_pot*W +: W];
          end
          default: begin
            mask_q  <= '1;
            stage_q <= wiper_flat;
          end
        endcase
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_pot
    always_ff @(posedge clk) begin
      if (finish && mask_q[p])
        store_q[(p*NR + int'(reg_q))*W +: W] <= stage_q[p*W +: W];
    end
  end

  assign store_flat = store_q;
  assign busy       = busy_q;

  logic [CW:0] run_len;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_len <= '0;
    else if (busy_q) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  // R7
  store_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q)) |-> $stable(store_q));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(frame_end));

  // R8
  commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (run_len == (CW+1)'(NV_CYCLES)));

  // R10
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_valid) |=> !pend_q);
endmodule

// File: rtl/quad_wiper_bank.sv
module quad_wiper_bank
  import wbank_pkg::*;
#(
  parameter int WIPER_W   = 6,
  parameter int N_POTS    = 4,
  parameter int N_REGS    = 4,
  parameter int NV_CYCLES = 1000000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  input  logic [2:0]                        cmd_op,
  input  logic [$clog2(N_POTS)-1:0]         cmd_pot,
  input  logic [$clog2(N_REGS)-1:0]         cmd_reg,
  input  logic [WIPER_W-1:0]                cmd_data,
  input  logic                              cmd_up,
  input  logic                              frame_end,
  input  logic [$clog2(N_POTS)-1:0]         rd_pot,
  input  logic [$clog2(N_REGS)-1:0]         rd_reg,
  output logic [WIPER_W-1:0]                rd_data,
  output logic                              wip,
  output logic [N_POTS*WIPER_W-1:0]         wiper_val,
  output logic [N_POTS*(1<<WIPER_W)-1:0]    tap_sel
);
  localparam int TAPS = 1 << WIPER_W;
  localparam int PW   = $clog2(N_POTS);
  localparam int RW   = $clog2(N_REGS);

  op_e                          op;
  logic [N_POTS*N_REGS*WIPER_W-1:0] store_flat;

  assign op = op_e'(cmd_op);

  wbank_nvstore #(
    .W(WIPER_W), .NP(N_POTS), .NR(N_REGS), .NV_CYCLES(NV_CYCLES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op),
    .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .wiper_flat(wiper_val), .frame_end(frame_end),
    .store_flat(store_flat), .busy(wip)
  );

  for (genvar p = 0; p < N_POTS; p++) begin : g_pot
    wbank_wiper #(
      .W(WIPER_W), .NR(N_REGS), .PW(PW), .RW(RW), .IDX(p)
    ) u_wiper (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(op),
      .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
      .cmd_up(cmd_up),
      .row_flat(store_flat[p*N_REGS*WIPER_W +: N_REGS*WIPER_W]),
      .wiper(wiper_val[p*WIPER_W +: WIPER_W])
    );

    wbank_tapdec #(.W(WIPER_W), .TAPS(TAPS)) u_dec (
      .wiper(wiper_val[p*WIPER_W +: WIPER_W]),
      .tap(tap_sel[p*TAPS +: TAPS])
    );

    // R6
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(tap_sel[p*TAPS +: TAPS]) && tap_sel[p*TAPS + int'(wiper_val[p*WIPER_W +: WIPER_W])]);
  end

  assign rd_data = store_flat[(int'(rd_pot)*N_REGS + int'(rd_reg))*WIPER_W +: WIPER_W];
endmodule

// File: tb/quad_wiper_bank_bench.sv
module quad_wiper_bank_bench;
  localparam int W  = 6;
  localparam int NP = 4;
  localparam int NR = 4;
  localparam int NV = 16;
  localparam int T  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_pot = '0;
  logic [1:0] cmd_reg = '0;
  logic [W-1:0] cmd_data = '0;
  logic cmd_up = 1'b0;
  logic frame_end = 1'b0;
  logic [1:0] rd_pot = '0;
  logic [1:0] rd_reg = '0;
  logic [W-1:0] rd_data;
  logic wip;
  logic [NP*W-1:0] wiper_val;
  logic [NP*T-1:0] tap_sel;

  int total = 0;
  int bad = 0;
  int exp_dr[NP][NR];
  int exp_w[NP];

  always #5 clk = ~clk;

  quad_wiper_bank #(.NV_CYCLES(NV)) u_quad_wiper_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_up(cmd_up),
    .frame_end(frame_end), .rd_pot(rd_pot), .rd_reg(rd_reg), .rd_data(rd_data),
    .wip(wip), .wiper_val(wiper_val), .tap_sel(tap_sel)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_wipers(input string req);
    logic [NP*T-1:0] e;
    e = '0;
    for (int p = 0; p < NP; p++) begin
      chk(wiper_val[p*W +: W] == W'(exp_w[p]), req, wiper_val[p*W +: W], exp_w[p]);
      e[p*T + exp_w[p]] = 1'b1;
    end
    chk(tap_sel == e, {req, " R6 taps"}, $countones(tap_sel), NP);
  endtask

  task automatic rd_check(input int p, input int r, input string req);
    rd_pot = 2'(p);
    rd_reg = 2'(r);
    #1;
    chk(rd_data == W'(exp_dr[p][r]), req, rd_data, exp_dr[p][r]);
  endtask

  task automatic issue(input int op, input int p, input int r, input int d, input bit up);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_pot   = 2'(p);
    cmd_reg   = 2'(r);
    cmd_data  = W'(d);
    cmd_up    = up;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic commit(input string req);
    pulse_end();
    chk(wip == 1'b1, {req, " R8 rise"}, wip, 1);
    repeat (NV - 1) @(negedge clk);
    chk(wip == 1'b1, {req, " R8 hold"}, wip, 1);
    @(negedge clk);
    chk(wip == 1'b0, {req, " R8 fall"}, wip, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(wip == 1'b0, "R1 wip in reset", wip, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wip == 1'b0, "R1 wip after reset", wip, 0);
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // R7, R11: write every data register, commit, read back
    for (int p = 0; p < NP; p++) begin
      for (int r = 0; r < NR; r++) begin
        exp_dr[p][r] = (p * 17 + r * 11 + 5) % 64;
        issue(4, p, r, exp_dr[p][r], 1'b0);
        if (p == 0 && r == 0) begin
          repeat (3) @(negedge clk);
          chk(wip == 1'b0, "R7 no commit without frame_end", wip, 0);
        end
        commit("R7");
        rd_check(p, r, "R7 R11 readback");
      end
    end

    // R8: frame_end without staged write does nothing
    pulse_end();
    chk(wip == 1'b0, "R8 idle frame_end", wip, 0);

    // R1: second reset loads R0 into wipers, data retained
    do_reset();
    for (int p = 0; p < NP; p++) exp_w[p] = exp_dr[p][0];
    check_wipers("R1 reload");
    for (int p = 0; p < NP; p++) rd_check(p, 3, "R1 retained");

    // R2, R6: sweep every value on pot 1
    for (int v = 0; v < T; v++) begin
      issue(1, 1, 0, v, 1'b0);
      exp_w[1] = v;
      check_wipers("R2 write wiper");
    end

    // R3: step up past the top, then down past the bottom
    for (int i = 0; i < 70; i++) begin
      issue(7, 2, 0, 0, 1'b1);
      exp_w[2] = (exp_w[2] < 63) ? exp_w[2] + 1 : 63;
      check_wipers("R3 step up");
    end
    for (int i = 0; i < 70; i++) begin
      issue(7, 2, 0, 0, 1'b0);
      exp_w[2] = (exp_w[2] > 0) ? exp_w[2] - 1 : 0;
      check_wipers("R3 step down");
    end

    // R4: single register to wiper
    for (int p = 0; p < NP; p++) begin
      for (int r = 0; r < NR; r++) begin
        issue(2, p, r, 0, 1'b0);
        exp_w[p] = exp_dr[p][r];
        check_wipers("R4 single xfer");
      end
    end

    // R5: global register to wiper
    for (int r = 0; r < NR; r++) begin
      issue(3, 0, r, 0, 1'b0);
      for (int p = 0; p < NP; p++) exp_w[p] = exp_dr[p][r];
      check_wipers("R5 global xfer");
    end

    // R9: single wiper to register, captured at command time
    issue(1, 3, 0, 42, 1'b0);
    issue(5, 3, 1, 0, 1'b0);
    issue(1, 3, 0, 9, 1'b0);
    exp_w[3] = 9;
    rd_check(3, 1, "R9 not before commit");
    commit("R9");
    exp_dr[3][1] = 42;
    rd_check(3, 1, "R9 single store");

    // R9: global wiper to register
    for (int p = 0; p < NP; p++) begin
      issue(1, p, 0, p * 10 + 3, 1'b0);
      exp_w[p] = p * 10 + 3;
    end
    issue(6, 0, 3, 0, 1'b0);
    commit("R9");
    for (int p = 0; p < NP; p++) begin
      exp_dr[p][3] = p * 10 + 3;
      rd_check(p, 3, "R9 global store");
    end

    // R10: commands during a commit are dropped; R4 still works
    issue(4, 0, 2, 60, 1'b0);
    pulse_end();
    chk(wip == 1'b1, "R10 busy", wip, 1);
    issue(4, 1, 2, 61, 1'b0);
    issue(5, 2, 2, 0, 1'b0);
    issue(6, 0, 1, 0, 1'b0);
    issue(2, 0, 0, 0, 1'b0);
    exp_w[0] = exp_dr[0][0];
    check_wipers("R4 during busy");
    pulse_end();
    repeat (NV) @(negedge clk);
    chk(wip == 1'b0, "R10 no second commit", wip, 0);
    pulse_end();
    chk(wip == 1'b0, "R10 nothing staged", wip, 0);
    exp_dr[0][2] = 60;
    rd_check(0, 2, "R10 first write lands");
    rd_check(1, 2, "R10 dropped write");
    rd_check(2, 2, "R10 dropped transfer");
    for (int p = 0; p < NP; p++) rd_check(p, 1, "R10 dropped global");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule